// File: doc/BRIEF.md
# Dual-Context Configuration Bank

This block keeps two complete configuration contexts, foreground and background, for a content-addressed memory datapath. Each context holds a control word, a pair of segment counter limits, an address pointer, a compare/write mask and a persistent source/destination select. Only the active context drives the outputs toward the datapath. A single-cycle swap command exchanges the roles of the two contexts and emits a one-cycle pulse that tells the compare logic to drop its current match result.

Software or a command decoder loads either context through a plain register write port that carries a context selector. It can therefore prepare the idle context while the active one keeps filtering traffic. A second mask register sits outside the banking and is shared by both contexts. Every memory access is signalled by a strobe. On each strobe the active address pointer moves up, moves down or holds, as the active control word selects. This lets a sequential block transfer walk memory without reloading the pointer.

The register port is always ready: a write completes in the cycle it is presented and there is no back-pressure. Readback is combinational from the stored state.

Top module: `cfg_ctx_bank`

## Requirements
- R1: While reset is asserted, and after it is released, the foreground context (act_bank = 0) is active, every register of both contexts and the shared mask read as zero, and match_clr is low.
- R2: A write with wr_en high stores wr_data into register wr_reg of the context chosen by wr_bank, and is visible on the next cycle. Register codes: 0 control (8 bits), 1 segment limits (bits 3:0 write limit, bits 7:4 read limit), 2 address (low AW bits), 3 mask 1 (DW bits), 4 source/destination (bits 2:0 source, bits 5:3 destination), 5 shared mask 2. rd_data returns the zero-extended stored value of register rd_reg in context rd_bank.
- R3: The act_* outputs always reflect the active context. Writes to the idle context and access strobes leave the active outputs and the idle context's address unchanged.
- R4: When swap_cmd is high at a clock edge, act_bank toggles at that edge. Consecutive swap cycles toggle on every edge.
- R5: match_clr is high for exactly the one cycle after each clock edge at which swap_cmd was high, and low otherwise.
- R6: With step mode 01 (control bits 1:0), each acc_stb advances the active address by one. The address wraps to 0 from DEPTH-1, or from any loaded value at or above DEPTH-1.
- R7: With step mode 10, each acc_stb lowers the active address by one, and the address wraps from 0 to DEPTH-1.
- R8: With step mode 00 or 11, acc_stb leaves the address unchanged.
- R9: A write to the active address register in the same cycle as acc_stb stores the written value; the step is discarded. The step always uses the control word held before that edge.
- R10: Mask 2 is a single register: a write to code 5 ignores wr_bank, both readback contexts show the same value, and a swap leaves it unchanged.
- R11: Register codes 6 and 7 are unused. Writes to them change no register, and reads of them return zero.
- R12: The active control word is decoded onto act_step (bits 1:0), act_mask_en (bit 2), act_match_en (bit 3) and act_full_en (bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 1 | Context targeted by the write (0 foreground, 1 background) |
| wr_reg | input | 3 | Register code for the write |
| wr_data | input | DW | Write data |
| rd_bank | input | 1 | Context for readback |
| rd_reg | input | 3 | Register code for readback |
| rd_data | output | DW | Readback data |
| swap_cmd | input | 1 | Exchange active and idle contexts |
| acc_stb | input | 1 | Memory access occurred; step the active address |
| act_bank | output | 1 | Currently active context |
| act_step | output | 2 | Active address step mode |
| act_mask_en | output | 1 | Active compare masking enable |
| act_match_en | output | 1 | Active match flag enable |
| act_full_en | output | 1 | Active full flag enable |
| act_ctrl | output | 8 | Active control word |
| act_seg_wr | output | 4 | Active write segment limit |
| act_seg_rd | output | 4 | Active read segment limit |
| act_addr | output | AW | Active address pointer |
| act_mask1 | output | DW | Active mask 1 |
| act_src | output | 3 | Active persistent source select |
| act_dst | output | 3 | Active persistent destination select |
| mask2 | output | DW | Shared mask 2 |
| match_clr | output | 1 | One-cycle pulse after a context swap |

## Verification
A wrong active-context flag sends every act_* field from the other context, and the ports show this on the first edge after the fault. A misrouted write instead stays hidden until that register is read back or its context becomes active. An address pointer that steps wrongly gives the wrong act_addr one cycle after the strobe. Wrap errors appear only at the exact end values 0, DEPTH-1 and loaded values beyond DEPTH-1, so those values are forced deliberately. A late or stretched match_clr shows on the cycle after a swap, and back-to-back swaps make a stretched pulse visible.

// File: rtl/cfg_ctx_pkg.sv
package cfg_ctx_pkg;

  localparam int CTRL_W = 8;
  localparam int SEG_W  = 4;
  localparam int SEL_W  = 3;
  localparam int REG_W  = 3;
  localparam int NUM_CTX = 2;

  typedef enum logic [REG_W-1:0] {
    RI_CTRL  = 3'd0,
    RI_SEG   = 3'd1,
    RI_ADDR  = 3'd2,
    RI_MASK1 = 3'd3,
    RI_PSD   = 3'd4,
    RI_MASK2 = 3'd5
  } reg_idx_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSVD = 2'b11
  } step_e;

  localparam int CB_MASK_EN  = 2;
  localparam int CB_MATCH_EN = 3;
  localparam int CB_FULL_EN  = 4;

endpackage

// File: rtl/cfg_addr_step.sv
module cfg_addr_step #(
  parameter int DEPTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] addr_o
);
  import cfg_ctx_pkg::*;

  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [AW-1:0] up_v;
  logic [AW-1:0] dn_v;

  generate
    if (POW2) begin : g_pow2
      assign up_v = addr_i + AW'(1);
      assign dn_v = addr_i - AW'(1);
    end else begin : g_cmp
      assign up_v = (addr_i >= TOP) ? '0 : addr_i + AW'(1);
      assign dn_v = (addr_i == '0) ? TOP : addr_i - AW'(1);
    end
  endgenerate

  always_comb begin
    unique case (step_e'(mode_i))
      STEP_INC: addr_o = up_v;
      STEP_DEC: addr_o = dn_v;
      default:  addr_o = addr_i;
    endcase
  end

endmodule

// File: rtl/cfg_ctx_set.sv
module cfg_ctx_set #(
  parameter int DEPTH = 48,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [cfg_ctx_pkg::REG_W-1:0]     wr_reg,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              is_active,
  input  logic                              acc_stb,
  output logic [cfg_ctx_pkg::CTRL_W-1:0]    ctrl_q,
  output logic [2*cfg_ctx_pkg::SEG_W-1:0]   seg_q,
  output logic [AW-1:0]                     addr_q,
  output logic [DW-1:0]                     mask1_q,
  output logic [cfg_ctx_pkg::SEL_W-1:0]     src_q,
  output logic [cfg_ctx_pkg::SEL_W-1:0]     dst_q
);
  import cfg_ctx_pkg::*;

  logic [AW-1:0] addr_nxt;
  logic          addr_wr;

  assign addr_wr = wr_en && (wr_reg == RI_ADDR);

  cfg_addr_step #(.DEPTH(DEPTH), .AW(AW)) u_step (
    .addr_i (addr_q),
    .mode_i (ctrl_q[1:0]),
    .addr_o (addr_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      seg_q   <= '0;
      addr_q  <= '0;
      mask1_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      if (is_active && acc_stb) addr_q <= addr_nxt;
      if (wr_en) begin
        case (reg_idx_e'(wr_reg))
          RI_CTRL:  ctrl_q  <= wr_data[CTRL_W-1:0];
          RI_SEG:   seg_q   <= wr_data[2*SEG_W-1:0];
          RI_ADDR:  addr_q  <= wr_data[AW-1:0];
          RI_MASK1: mask1_q <= wr_data;
          RI_PSD: begin
            src_q <= wr_data[SEL_W-1:0];
            dst_q <= wr_data[2*SEL_W-1:SEL_W];
          end
          default: ;
        endcase
      end
    end
  end

  // R3: an idle context with no write keeps every field
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_active && !wr_en) |=> ($stable(addr_q) && $stable(ctrl_q) && $stable(mask1_q)
                                && $stable(seg_q) && $stable(src_q) && $stable(dst_q)));

  // R6: increment wraps from the top address to zero
  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && acc_stb && !addr_wr && ctrl_q[1:0] == 2'b01 && addr_q == AW'(DEPTH-1))
      |=> (addr_q == '0));

  // R7: decrement wraps from zero to the top address
  p_dec_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && acc_stb && !addr_wr && ctrl_q[1:0] == 2'b10 && addr_q == '0)
      |=> (addr_q == AW'(DEPTH-1)));

  // R8: hold modes keep the address on a strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !addr_wr && ctrl_q[1] == ctrl_q[0]) |=> $stable(addr_q));

  // R9: a direct load beats the step
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (addr_q == $past(wr_data[AW-1:0])));

endmodule

// File: rtl/cfg_ctx_bank.sv
module cfg_ctx_bank #(
  parameter int DEPTH = 48,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_bank,
  input  logic [cfg_ctx_pkg::REG_W-1:0]   wr_reg,
  input  logic [DW-1:0]                   wr_data,
  input  logic                            rd_bank,
  input  logic [cfg_ctx_pkg::REG_W-1:0]   rd_reg,
  output logic [DW-1:0]                   rd_data,
  input  logic                            swap_cmd,
  input  logic                            acc_stb,
  output logic                            act_bank,
  output logic [1:0]                      act_step,
  output logic                            act_mask_en,
  output logic                            act_match_en,
  output logic                            act_full_en,
  output logic [cfg_ctx_pkg::CTRL_W-1:0]  act_ctrl,
  output logic [cfg_ctx_pkg::SEG_W-1:0]   act_seg_wr,
  output logic [cfg_ctx_pkg::SEG_W-1:0]   act_seg_rd,
  output logic [AW-1:0]                   act_addr,
  output logic [DW-1:0]                   act_mask1,
  output logic [cfg_ctx_pkg::SEL_W-1:0]   act_src,
  output logic [cfg_ctx_pkg::SEL_W-1:0]   act_dst,
  output logic [DW-1:0]                   mask2,
  output logic                            match_clr
);
  import cfg_ctx_pkg::*;

  logic [CTRL_W-1:0]  s_ctrl  [NUM_CTX];
  logic [2*SEG_W-1:0] s_seg   [NUM_CTX];
  logic [AW-1:0]      s_addr  [NUM_CTX];
  logic [DW-1:0]      s_mask1 [NUM_CTX];
  logic [SEL_W-1:0]   s_src   [NUM_CTX];
  logic [SEL_W-1:0]   s_dst   [NUM_CTX];

  logic          act_q;
  logic          clr_q;
  logic [DW-1:0] mask2_q;
  logic          banked_wr;

  assign banked_wr = wr_en && (wr_reg != RI_MASK2);

  generate
    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      cfg_ctx_set #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_set (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (banked_wr && (wr_bank == 1'(g))),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data),
        .is_active (act_q == 1'(g)),
        .acc_stb   (acc_stb),
        .ctrl_q    (s_ctrl[g]),
        .seg_q     (s_seg[g]),
        .addr_q    (s_addr[g]),
        .mask1_q   (s_mask1[g]),
        .src_q     (s_src[g]),
        .dst_q     (s_dst[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      clr_q   <= 1'b0;
      mask2_q <= '0;
    end else begin
      act_q <= act_q ^ swap_cmd;
      clr_q <= swap_cmd;
      if (wr_en && wr_reg == RI_MASK2) mask2_q <= wr_data;
    end
  end

  always_comb begin
    act_ctrl   = s_ctrl[act_q];
    act_seg_wr = s_seg[act_q][SEG_W-1:0];
    act_seg_rd = s_seg[act_q][2*SEG_W-1:SEG_W];
    act_addr   = s_addr[act_q];
    act_mask1  = s_mask1[act_q];
    act_src    = s_src[act_q];
    act_dst    = s_dst[act_q];
  end

  assign act_step     = act_ctrl[1:0];
  assign act_mask_en  = act_ctrl[CB_MASK_EN];
  assign act_match_en = act_ctrl[CB_MATCH_EN];
  assign act_full_en  = act_ctrl[CB_FULL_EN];
  assign act_bank     = act_q;
  assign mask2        = mask2_q;
  assign match_clr    = clr_q;

  always_comb begin
    case (reg_idx_e'(rd_reg))
      RI_CTRL:  rd_data = DW'(s_ctrl[rd_bank]);
      RI_SEG:   rd_data = DW'(s_seg[rd_bank]);
      RI_ADDR:  rd_data = DW'(s_addr[rd_bank]);
      RI_MASK1: rd_data = s_mask1[rd_bank];
      RI_PSD:   rd_data = DW'({s_dst[rd_bank], s_src[rd_bank]});
      RI_MASK2: rd_data = mask2_q;
      default:  rd_data = '0;
    endcase
  end

  // R4: a swap command flips the active context at that edge
  p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_cmd |=> (act_bank != $past(act_bank)));

  p_noswap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_cmd |=> $stable(act_bank));

  // R5: match clear is a single cycle pulse following a swap
  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_cmd |=> match_clr);

  p_clr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_cmd |=> !match_clr);

  // R10: shared mask changes only on its own write code
  p_mask2_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_reg == RI_MASK2) |=> $stable(mask2));

  // R1: reset state
  always_comb begin
    if (!rst_n) p_reset_r1: assert (act_bank == 1'b0 && match_clr == 1'b0 && mask2 == '0);
  end

endmodule

// File: tb/test_cfg_ctx_bank.sv
`timescale 1ns/1ps
module test_cfg_ctx_bank;
  localparam int DEPTH = 48;
  localparam int DW    = 32;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, wr_en, wr_bank, rd_bank, swap_cmd, acc_stb;
  logic [2:0]    wr_reg, rd_reg;
  logic [DW-1:0] wr_data, rd_data, act_mask1, mask2;
  logic          act_bank, act_mask_en, act_match_en, act_full_en, match_clr;
  logic [1:0]    act_step;
  logic [7:0]    act_ctrl;
  logic [3:0]    act_seg_wr, act_seg_rd;
  logic [AW-1:0] act_addr;
  logic [2:0]    act_src, act_dst;

  cfg_ctx_bank #(.DEPTH(DEPTH), .DW(DW)) i_cfg_ctx_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_bank(rd_bank), .rd_reg(rd_reg), .rd_data(rd_data),
    .swap_cmd(swap_cmd), .acc_stb(acc_stb), .act_bank(act_bank), .act_step(act_step),
    .act_mask_en(act_mask_en), .act_match_en(act_match_en), .act_full_en(act_full_en),
    .act_ctrl(act_ctrl), .act_seg_wr(act_seg_wr), .act_seg_rd(act_seg_rd),
    .act_addr(act_addr), .act_mask1(act_mask1), .act_src(act_src), .act_dst(act_dst),
    .mask2(mask2), .match_clr(match_clr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_ctrl [2];
  logic [31:0] m_seg  [2];
  logic [31:0] m_addr [2];
  logic [31:0] m_m1   [2];
  logic [31:0] m_psd  [2];
  logic [31:0] m_m2;
  logic        m_act, m_clr;

  task automatic chk(string req, string what, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  function automatic logic [31:0] mread(logic b, logic [2:0] r);
    case (r)
      3'd0: return m_ctrl[b];
      3'd1: return m_seg[b];
      3'd2: return m_addr[b];
      3'd3: return m_m1[b];
      3'd4: return m_psd[b];
      3'd5: return m_m2;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp_outputs();
    logic [31:0] c;
    c = m_ctrl[m_act];
    chk("R4", "act_bank", 32'(act_bank), 32'(m_act));
    chk("R5", "match_clr", 32'(match_clr), 32'(m_clr));
    chk("R3", "act_ctrl", 32'(act_ctrl), c);
    chk("R12", "act_step", 32'(act_step), 32'(c[1:0]));
    chk("R12", "act_mask_en", 32'(act_mask_en), 32'(c[2]));
    chk("R12", "act_match_en", 32'(act_match_en), 32'(c[3]));
    chk("R12", "act_full_en", 32'(act_full_en), 32'(c[4]));
    chk("R3", "act_seg_wr", 32'(act_seg_wr), 32'(m_seg[m_act][3:0]));
    chk("R3", "act_seg_rd", 32'(act_seg_rd), 32'(m_seg[m_act][7:4]));
    chk("R6/R7/R8/R9", "act_addr", 32'(act_addr), m_addr[m_act]);
    chk("R3", "act_mask1", act_mask1, m_m1[m_act]);
    chk("R3", "act_src", 32'(act_src), 32'(m_psd[m_act][2:0]));
    chk("R3", "act_dst", 32'(act_dst), 32'(m_psd[m_act][5:3]));
    chk("R10", "mask2", mask2, m_m2);
  endtask

  task automatic cyc(logic we, logic wb, logic [2:0] wr, logic [31:0] wd,
                     logic rb, logic [2:0] rr, logic sw, logic acc);
    logic [31:0] a;
    wr_en = we; wr_bank = wb; wr_reg = wr; wr_data = wd;
    rd_bank = rb; rd_reg = rr; swap_cmd = sw; acc_stb = acc;
    #1;
    chk((rr >= 3'd6) ? "R11" : "R2", "rd_data", rd_data, mread(rb, rr));
    if (acc) begin
      a = m_addr[m_act];
      case (m_ctrl[m_act][1:0])
        2'b01: a = (a >= DEPTH - 1) ? 32'd0 : a + 1;
        2'b10: a = (a == 0) ? DEPTH - 1 : a - 1;
        default: ;
      endcase
      m_addr[m_act] = a;
    end
    if (we) begin
      case (wr)
        3'd0: m_ctrl[wb] = wd & 32'hFF;
        3'd1: m_seg[wb]  = wd & 32'hFF;
        3'd2: m_addr[wb] = wd & 32'h3F;
        3'd3: m_m1[wb]   = wd;
        3'd4: m_psd[wb]  = wd & 32'h3F;
        3'd5: m_m2       = wd;
        default: ;
      endcase
    end
    m_act = m_act ^ sw;
    m_clr = sw;
    @(posedge clk);
    #1;
    cmp_outputs();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_bank = 0; wr_reg = 0; wr_data = 0;
    rd_bank = 0; rd_reg = 0; swap_cmd = 0; acc_stb = 0;
    for (int b = 0; b < 2; b++) begin
      m_ctrl[b] = 0; m_seg[b] = 0; m_addr[b] = 0; m_m1[b] = 0; m_psd[b] = 0;
    end
    m_m2 = 0; m_act = 0; m_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk("R1", "act_bank in reset", 32'(act_bank), 32'd0);
    chk("R1", "match_clr in reset", 32'(match_clr), 32'd0);
    chk("R1", "act_addr in reset", 32'(act_addr), 32'd0);
    rd_bank = 1; rd_reg = 3'd3; #1;
    chk("R1", "bg mask1 in reset", rd_data, 32'd0);
    rst_n = 1;
    @(negedge clk);
    cmp_outputs();

    // R6: increment and wrap
    cyc(1, 0, 3'd0, 32'h01, 0, 3'd0, 0, 0);
    cyc(1, 0, 3'd2, DEPTH - 2, 0, 3'd2, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    chk("R6", "wrap to zero", 32'(act_addr), 32'd0);
    cyc(1, 0, 3'd2, 32'd63, 0, 3'd2, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    chk("R6", "wrap from beyond top", 32'(act_addr), 32'd0);
    // R7: decrement and wrap
    cyc(1, 0, 3'd0, 32'h02, 0, 3'd0, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    chk("R7", "wrap to top", 32'(act_addr), DEPTH - 1);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    // R8: hold modes
    cyc(1, 0, 3'd0, 32'h00, 0, 3'd0, 0, 1);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    cyc(1, 0, 3'd0, 32'h1F, 0, 3'd0, 0, 1);
    cyc(0, 0, 0, 0, 0, 3'd2, 0, 1);
    chk("R8", "reserved mode holds", 32'(act_addr), 32'd45);
    // R9: load beats step, step uses old control
    cyc(1, 0, 3'd0, 32'h01, 0, 3'd0, 0, 0);
    cyc(1, 0, 3'd2, 32'd5, 0, 3'd2, 0, 1);
    chk("R9", "load wins", 32'(act_addr), 32'd5);
    cyc(1, 0, 3'd0, 32'h02, 0, 3'd0, 0, 1);
    chk("R9", "step with old ctrl", 32'(act_addr), 32'd6);
    // R3: idle context loads
    cyc(1, 1, 3'd0, 32'h1E, 0, 3'd0, 0, 1);
    cyc(1, 1, 3'd3, 32'hA5A5_0F0F, 1, 3'd0, 0, 1);
    cyc(1, 1, 3'd4, 32'h2B, 1, 3'd3, 0, 0);
    cyc(1, 1, 3'd1, 32'h7C, 1, 3'd4, 0, 0);
    cyc(1, 1, 3'd2, 32'd9, 1, 3'd1, 0, 1);
    // R4 R5: swaps including back-to-back
    cyc(0, 0, 0, 0, 1, 3'd2, 1, 0);
    chk("R4", "bg active", 32'(act_bank), 32'd1);
    chk("R5", "clear pulse", 32'(match_clr), 32'd1);
    cyc(0, 0, 0, 0, 0, 3'd0, 0, 1);
    chk("R5", "pulse ends", 32'(match_clr), 32'd0);
    cyc(0, 0, 0, 0, 0, 3'd0, 1, 0);
    cyc(0, 0, 0, 0, 0, 3'd0, 1, 0);
    chk("R4", "second toggle", 32'(act_bank), 32'd1);
    // R10: shared mask
    cyc(1, 1, 3'd5, 32'hDEAD_BEEF, 0, 3'd5, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'd5, 1, 0);
    cyc(0, 0, 0, 0, 1, 3'd5, 0, 0);
    chk("R10", "mask2 after swap", mask2, 32'hDEAD_BEEF);
    // R11: unused codes
    cyc(1, 0, 3'd6, 32'hFFFF_FFFF, 0, 3'd6, 0, 0);
    cyc(1, 1, 3'd7, 32'hFFFF_FFFF, 1, 3'd7, 0, 0);
    cyc(0, 0, 0, 0, 1, 3'd6, 0, 0);
    for (int r = 0; r < 6; r++) cyc(0, 0, 0, 0, 1, 3'(r), 0, 0);
    for (int r = 0; r < 6; r++) cyc(0, 0, 0, 0, 0, 3'(r), 0, 0);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      logic [2:0]  wr;
      wr = 3'($urandom % 8);
      case ($urandom % 4)
        0: wd = DEPTH - 1;
        1: wd = 32'd0;
        2: wd = (wr == 3'd0) ? 32'($urandom % 4) : 32'd63;
        default: wd = $urandom;
      endcase
      cyc(($urandom % 3) == 0, 1'($urandom), wr, wd, 1'($urandom), 3'($urandom),
          ($urandom % 9) == 0, ($urandom % 2) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule